// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores received Ethernet frames in host memory. Software builds a circular list of descriptors. Each descriptor is four 32-bit words at consecutive word addresses: a status word, a control word, a buffer address and a spare link word that this block never reads. Software marks a descriptor as available by setting the device-ownership bit in its status word. When a frame begins, the block reads the descriptor at its ring pointer and checks that bit. If the descriptor is available, the block copies the frame bytes into the buffer and then writes a completion status that hands the descriptor back to software.

The frame arrives as a byte stream with start-of-frame, end-of-frame and error markers, under a valid/ready handshake. Memory is reached through a single word-wide port. The memory accepts every request in the cycle it is made and returns read data in the following cycle. If the pointed-to descriptor is not available, the frame is drained and discarded, and a sticky flag tells software that no buffer was ready. A start pulse loads the ring base into the pointer and arms the block.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: A `start` pulse loads `ring_base` into the ring pointer and clears `rx_nobuf`. The next frame is then placed in the descriptor at `ring_base`.
- R2: When a byte with `rx_sof` is presented while the block waits for a frame, the block issues three reads in three consecutive cycles: pointer+0, pointer+4 and pointer+8. `rx_ready` stays low until the ownership decision has been made.
- R3: If bit 31 of the fetched status word is 0, the whole frame is accepted and discarded. No memory write occurs, `rx_nobuf` is set, and the pointer is left unchanged, so the next frame fetches the same descriptor again.
- R4: Byte k of a stored frame is written to buffer address + k, in little-endian lane order within a 32-bit word. The low two bits of the buffer address are treated as zero. A partial final word is written with its byte enables set only for the bytes that were received.
- R5: The buffer size is taken from bits [SIZE_W-1:0] of the control word. Bytes at index size or higher are never written and cause bit 15 of the status to be set. A frame whose length equals the size is stored without that error.
- R6: After the last byte, exactly one full-word write goes to pointer+0. That word carries the byte count in bits [16+LEN_W-1:16], counting every received byte including the 4 trailing CRC bytes. It also has bit 8 set, bit 31 clear and bit 15 as the error summary.
- R7: After the status write-back the pointer advances by 16 bytes. If bit 25 of the control word was set, the pointer returns to the ring base instead.
- R8: Once set, `rx_nobuf` stays set until the next `start`, regardless of later frames.
- R9: Before the first `start`, and for any byte without `rx_sof` while the block waits for a frame, the byte is accepted (`rx_ready` high) and dropped with no memory access.
- R10: An `rx_err` on any accepted byte of a stored frame sets bit 15 of its status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load ring base into pointer and arm the block |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Receive error reported with this byte |
| rx_ready | output | 1 | Byte is accepted on this clock edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_nobuf | output | 1 | Sticky flag: a frame found no available descriptor |

## Verification
Two functions can act on the same byte. The last byte of a frame can both cross the buffer-size limit and trigger the flush of a partial word. Alternatively, the final byte lands exactly on the limit, so its word write is the last legal one. The bench provokes this with directed frames whose length equals the size and whose length exceeds it by less than a word, and with random lengths and sizes around each other. For each frame it judges the outcome by comparing every buffer byte against the sent data or the prefilled pattern, and by checking the error bit in the written-back status. A second overlap, the status write-back on a descriptor marked end-of-ring, is judged by where the following frame lands.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int DESC_WORDS = 4;
   localparam int OWN_BIT    = 31;
   localparam int EOR_BIT    = 25;
   localparam int ES_BIT     = 15;
   localparam int LS_BIT     = 8;
   localparam int LEN_LSB    = 16;

   typedef enum logic [3:0] {
      RX_OFF,
      RX_ARM,
      RX_F0,
      RX_F1,
      RX_F2,
      RX_F3,
      RX_RECV,
      RX_DROP,
      RX_WB
   } rxr_state_e;
endpackage

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             byte_vld,
   input  logic [7:0]       byte_dat,
   input  logic             keep,
   input  logic             last,
   output logic             wr_fire,
   output logic [31:0]      wr_word,
   output logic [3:0]       wr_be,
   output logic [IDX_W-1:0] wr_idx
);
   logic [1:0]       lane_q;
   logic [31:0]      acc_q;
   logic [3:0]       be_q;
   logic [IDX_W-1:0] idx_q;
   logic [31:0]      word_n;
   logic [3:0]       be_n;
   logic             flush;

   // one lane slot per byte position, little-endian
   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign word_n[8*g +: 8] = (lane_q == 2'(g)) ? byte_dat : acc_q[8*g +: 8];
      assign be_n[g]          = be_q[g] | ((lane_q == 2'(g)) & keep);
   end

   assign flush   = byte_vld && ((lane_q == 2'd3) || last);
   assign wr_fire = flush && (be_n != 4'd0);
   assign wr_word = word_n;
   assign wr_be   = be_n;
   assign wr_idx  = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q <= '0;
         acc_q  <= '0;
         be_q   <= '0;
         idx_q  <= '0;
      end else if (clear) begin
         lane_q <= '0;
         acc_q  <= '0;
         be_q   <= '0;
         idx_q  <= '0;
      end else if (byte_vld) begin
         if (flush) begin
            lane_q <= '0;
            acc_q  <= '0;
            be_q   <= '0;
            idx_q  <= idx_q + IDX_W'(1);
         end else begin
            lane_q <= lane_q + 2'd1;
            acc_q  <= word_n;
            be_q   <= be_n;
         end
      end
   end

   p_flush_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !clear) |=> (lane_q == 2'd0 && be_q == 4'd0));
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int ADDR_W = 32,
   parameter int STEP_B = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              advance,
   input  logic              wrap,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_B);
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ptr    <= '0;
      end else if (load) begin
         base_q <= base_in;
         ptr    <= base_in;
      end else if (advance) begin
         ptr <= wrap ? base_q : ptr + STEP;
      end
   end

   p_wrap_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && wrap && !load) |=> (ptr == $past(base_q)));
   p_step_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !wrap && !load) |=> (ptr == $past(ptr) + STEP));
   p_load_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ptr == $past(base_in)));
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
   import rxr_pkg::*;
#(
   parameter int LEN_W = 14
) (
   input  logic [LEN_W-1:0] len,
   input  logic             err,
   output logic [31:0]      word
);
   always_comb begin
      word                   = '0;
      word[LEN_LSB +: LEN_W] = len;
      word[ES_BIT]           = err;
      word[LS_BIT]           = 1'b1;
      word[OWN_BIT]          = 1'b0;
   end
endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer
   import rxr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 11,
   parameter int LEN_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_err,
   output logic              rx_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_be,
   input  logic [31:0]       mem_rdata,
   output logic              rx_nobuf
);
   localparam int IDX_W  = LEN_W - 2;
   localparam int STEP_B = DESC_WORDS * 4;

   if (SIZE_W > LEN_W) begin : g_bad_size
      $error("SIZE_W must not exceed LEN_W");
   end
   if (LEN_W > 15 || LEN_W < 4) begin : g_bad_len
      $error("LEN_W must lie in 4..15 so the status top bit stays clear");
   end
   if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must lie in 8..32");
   end

   rxr_state_e state_q, state_d;
   logic [ADDR_W-1:0] ptr;
   logic              own_q;
   logic [SIZE_W-1:0] size_q;
   logic              eor_q;
   logic [ADDR_W-1:0] buf_q;
   logic [LEN_W-1:0]  cnt_q;
   logic              ovf_q, err_q, rbu_q;
   logic              acc_byte, keep, frm_clr, adv;
   logic              pk_fire;
   logic [31:0]       pk_word;
   logic [3:0]        pk_be;
   logic [IDX_W-1:0]  pk_idx;
   logic [31:0]       stat_word;
   logic              unused_rd;

   assign unused_rd = ^mem_rdata;

   // ---------------- control ----------------
   always_comb begin
      state_d = state_q;
      if (start) begin
         state_d = RX_ARM;
      end else begin
         unique case (state_q)
            RX_OFF:  state_d = RX_OFF;
            RX_ARM:  if (rx_valid && rx_sof) state_d = RX_F0;
            RX_F0:   state_d = RX_F1;
            RX_F1:   state_d = RX_F2;
            RX_F2:   state_d = RX_F3;
            RX_F3:   state_d = own_q ? RX_RECV : RX_DROP;
            RX_RECV: if (rx_valid && rx_eof) state_d = RX_WB;
            RX_DROP: if (rx_valid && rx_eof) state_d = RX_ARM;
            RX_WB:   state_d = RX_ARM;
            default: state_d = RX_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RX_OFF;
      else        state_q <= state_d;
   end

   always_comb begin
      unique case (state_q)
         RX_OFF, RX_RECV, RX_DROP: rx_ready = 1'b1;
         RX_ARM:                   rx_ready = !rx_sof;
         default:                  rx_ready = 1'b0;
      endcase
   end

   // ---------------- descriptor capture ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= 1'b0;
         size_q <= '0;
         eor_q  <= 1'b0;
         buf_q  <= '0;
      end else begin
         if (state_q == RX_F1) own_q <= mem_rdata[OWN_BIT];
         if (state_q == RX_F2) begin
            size_q <= mem_rdata[SIZE_W-1:0];
            eor_q  <= mem_rdata[EOR_BIT];
         end
         if (state_q == RX_F3) buf_q <= ADDR_W'(mem_rdata) & ~ADDR_W'(3);
      end
   end

   // ---------------- frame accounting ----------------
   assign frm_clr  = (state_q == RX_F3);
   assign acc_byte = (state_q == RX_RECV) && rx_valid;
   assign keep     = cnt_q < LEN_W'(size_q);
   assign adv      = (state_q == RX_WB) && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         err_q <= 1'b0;
      end else if (frm_clr) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         err_q <= 1'b0;
      end else if (acc_byte) begin
         if (cnt_q != {LEN_W{1'b1}}) cnt_q <= cnt_q + LEN_W'(1);
         if (!keep)  ovf_q <= 1'b1;
         if (rx_err) err_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rbu_q <= 1'b0;
      else if (start)                      rbu_q <= 1'b0;
      else if (state_q == RX_F3 && !own_q) rbu_q <= 1'b1;
   end
   assign rx_nobuf = rbu_q;

   // ---------------- sub-blocks ----------------
   rxr_byte_packer #(.IDX_W(IDX_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (frm_clr),
      .byte_vld (acc_byte),
      .byte_dat (rx_data),
      .keep     (keep),
      .last     (rx_eof),
      .wr_fire  (pk_fire),
      .wr_word  (pk_word),
      .wr_be    (pk_be),
      .wr_idx   (pk_idx)
   );

   rxr_ring_ptr #(.ADDR_W(ADDR_W), .STEP_B(STEP_B)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .base_in (ring_base),
      .advance (adv),
      .wrap    (eor_q),
      .ptr     (ptr)
   );

   rxr_status_fmt #(.LEN_W(LEN_W)) u_fmt (
      .len  (cnt_q),
      .err  (ovf_q | err_q),
      .word (stat_word)
   );

   // ---------------- memory port ----------------
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ptr;
      mem_wdata = '0;
      mem_be    = 4'hF;
      unique case (state_q)
         RX_F0: mem_req = 1'b1;
         RX_F1: begin
            mem_req  = 1'b1;
            mem_addr = ptr + ADDR_W'(4);
         end
         RX_F2: begin
            mem_req  = 1'b1;
            mem_addr = ptr + ADDR_W'(8);
         end
         RX_RECV: begin
            mem_req   = pk_fire;
            mem_we    = pk_fire;
            mem_addr  = buf_q + (ADDR_W'(pk_idx) << 2);
            mem_wdata = pk_word;
            mem_be    = pk_be;
         end
         RX_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = stat_word;
         end
         default: ;
      endcase
   end

   // ---------------- assertions ----------------
   p_fetch_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_F0 && !start) |=>
         (mem_req && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(4)));
   p_fetch_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q inside {RX_F0, RX_F1, RX_F2, RX_F3}) |-> !rx_ready);
   p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_DROP) |-> !mem_req);
   p_nobuf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_nobuf && !start) |=> rx_nobuf);
   p_wb_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && state_q == RX_WB) |->
         (!mem_wdata[OWN_BIT] && mem_wdata[LS_BIT] && mem_be == 4'hF));
   p_write_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_be != 4'd0));
endmodule

// File: tb/tb_rx_desc_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_desc_ring_writer;
   localparam int ADDR_W = 32;
   localparam int DBASE  = 32'h40;
   localparam int BBASE  = 32'h200;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] ring_base = '0;
   logic              rx_valid = 1'b0;
   logic [7:0]        rx_data = '0;
   logic              rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
   logic              rx_ready, mem_req, mem_we, rx_nobuf;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_wdata, mem_rdata;
   logic [3:0]        mem_be;

   always #4 clk = ~clk;

   rx_desc_ring_writer dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_err(rx_err), .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rdata(mem_rdata), .rx_nobuf(rx_nobuf)
   );

   // memory model: synchronous, read data one cycle later
   logic [31:0] mem [0:1023];
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int g = 0; g < 4; g++)
               if (mem_be[g]) mem[mem_addr[11:2]][8*g +: 8] <= mem_wdata[8*g +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[11:2]];
         end
      end
   end

   int errors = 0, checks = 0, cyc = 0, rd_n = 0, wr_cnt = 0;
   int rd_addr [0:7];
   int rd_cyc  [0:7];
   logic [7:0] frm [0:255];
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      #2;
      if (mem_req) begin
         if (mem_we) wr_cnt++;
         else begin
            if (rd_n < 8) begin rd_addr[rd_n] = mem_addr; rd_cyc[rd_n] = cyc; end
            rd_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input int a);
      return mem[a >> 2][8*(a & 3) +: 8];
   endfunction

   function automatic int daddr(input int i); return DBASE + 16 * i; endfunction
   function automatic int baddr(input int i); return BBASE + 128 * i; endfunction

   task automatic prep(input int i, input bit own, input int size);
      mem[daddr(i) >> 2]       = own ? 32'h8000_0000 : 32'h0;
      mem[(daddr(i) >> 2) + 1] = ((i == 2) ? 32'h0200_0000 : 32'h0) | size;
      mem[(daddr(i) >> 2) + 2] = baddr(i);
      mem[(daddr(i) >> 2) + 3] = 32'h0;
      for (int w = 0; w < 32; w++) mem[(baddr(i) >> 2) + w] = 32'hA5A5_A5A5;
   endtask

   task automatic send(input int len, input bit err, input bit sof);
      bit rdy;
      rd_n = 0; wr_cnt = 0;
      for (int k = 0; k < len; k++) begin
         frm[k] = 8'($urandom);
         @(negedge clk);
         rx_valid = 1; rx_data = frm[k];
         rx_sof = sof && (k == 0); rx_eof = (k == len - 1); rx_err = err && (k == len - 1);
         forever begin
            #1 rdy = rx_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
         end
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
   endtask

   task automatic pulse_start(input int b);
      @(negedge clk); start = 1; ring_base = b;
      @(negedge clk); start = 0;
   endtask

   // check a stored frame in descriptor i (R2, R4, R5, R6, R10 as flagged)
   task automatic check_frame(input int i, input int size, input int len, input bit err, input string tag);
      int n, bad, keepn;
      logic [31:0] exp;
      bit es;
      repeat (3) @(negedge clk);
      es = err || (len > size);
      exp = (32'(len) << 16) | (32'(es) << 15) | 32'h100;
      chk(mem[daddr(i) >> 2] == exp, {tag, " R6 status word"}, mem[daddr(i) >> 2], exp);
      keepn = (len < size) ? len : size;
      bad = 0;
      for (int k = 0; k < keepn; k++) if (mbyte(baddr(i) + k) != frm[k]) bad++;
      chk(bad == 0, {tag, " R4 buffer bytes"}, bad, 0);
      bad = 0;
      for (int k = keepn; k < 128; k++) if (mbyte(baddr(i) + k) != 8'hA5) bad++;
      chk(bad == 0, {tag, " R5 bytes past data/limit untouched"}, bad, 0);
      n = 0;
      if (rd_n == 3 && rd_addr[0] == daddr(i) && rd_addr[1] == daddr(i) + 4 &&
          rd_addr[2] == daddr(i) + 8 && rd_cyc[1] == rd_cyc[0] + 1 && rd_cyc[2] == rd_cyc[1] + 1) n = 1;
      chk(n == 1, {tag, " R2 fetch reads"}, rd_addr[0], daddr(i));
   endtask

   initial begin
      int cur, sz, ln;
      bit er;
      void'($urandom(32'd1234));
      for (int w = 0; w < 1024; w++) mem[w] = '0;
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      chk(rx_ready == 1 && mem_req == 0, "R9 reset: idle and draining", {rx_ready, mem_req}, 2'b10);
      chk(rx_nobuf == 0, "R8 reset: no-buffer flag clear", rx_nobuf, 0);

      for (int i = 0; i < 3; i++) prep(i, 1, 64);
      send(10, 0, 1);
      repeat (3) @(negedge clk);
      chk(rd_n == 0 && wr_cnt == 0, "R9 frame before start ignored", rd_n + wr_cnt, 0);

      pulse_start(DBASE);
      #1 chk(rx_nobuf == 0, "R1 start armed", rx_nobuf, 0);
      // A: partial final word
      prep(0, 1, 64); send(37, 0, 1); check_frame(0, 64, 37, 0, "A");
      // B: overflow by three bytes
      prep(1, 1, 20); send(23, 0, 1); check_frame(1, 20, 23, 0, "B R5");
      // C: error flag, end-of-ring descriptor
      prep(2, 1, 100); send(12, 1, 1); check_frame(2, 100, 12, 1, "C R10");
      // D: length equals size, must land at base (R7 wrap)
      prep(0, 1, 20); send(20, 0, 1); check_frame(0, 20, 20, 0, "D R7 R5");
      // E: descriptor 1 not owned
      prep(1, 0, 64); send(9, 0, 1);
      repeat (3) @(negedge clk);
      chk(rx_nobuf == 1, "R3 no-buffer flag set", rx_nobuf, 1);
      chk(wr_cnt == 0, "R3 no write on drop", wr_cnt, 0);
      chk(mem[daddr(1) >> 2] == 0, "R3 descriptor untouched", mem[daddr(1) >> 2], 0);
      repeat (5) @(negedge clk);
      chk(rx_nobuf == 1, "R8 flag holds", rx_nobuf, 1);
      // F: same descriptor retried after rearm
      prep(1, 1, 64); send(8, 0, 1); check_frame(1, 64, 8, 0, "F R3 retry");
      chk(rx_nobuf == 1, "R8 flag holds after good frame", rx_nobuf, 1);
      // G: stray byte without start-of-frame
      send(1, 0, 0);
      repeat (3) @(negedge clk);
      chk(rd_n == 0 && wr_cnt == 0, "R9 stray byte dropped", rd_n + wr_cnt, 0);
      // H: restart, single byte frame goes to base
      pulse_start(DBASE);
      #1 chk(rx_nobuf == 0, "R1 start clears flag", rx_nobuf, 0);
      prep(0, 1, 64); send(1, 0, 1); check_frame(0, 64, 1, 0, "H R1");

      cur = 1;
      for (int f = 0; f < 16; f++) begin
         sz = 1 + ($urandom % 100);
         ln = (f % 4 == 0) ? sz + ($urandom % 4) : 1 + ($urandom % 110);
         er = ($urandom % 5) == 0;
         prep(cur, 1, sz); send(ln, er, 1); check_frame(cur, sz, ln, er, "rand R7");
         cur = (cur == 2) ? 0 : cur + 1;
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule